// File: doc/BRIEF.md
# Pin Interrupt Controller with Set/Clear Enable Aliases

This block turns eight already-routed GPIO inputs into eight interrupt lines. Each line can fire on a rising edge, a falling edge, or both, or it can follow a high or low input level. Software sees ten 32-bit registers on a simple memory-mapped write port with a combinational read port. Only the low eight bits of each word are meaningful. The channel enables have write-one-to-set and write-one-to-clear aliases, so one channel can be switched on or off without reading the register first.

Edge events are held in sticky status bits until software writes ones to clear them. Two further flag registers record every raw rising and falling transition, whether or not the channel is enabled. Interrupt line n is meant to drive the n-th of eight consecutive inputs of a downstream interrupt controller.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, all channels are in edge mode with both enables off, and `irq_out` is 0.
- R2: In the word at 0x00, bit n = 1 puts channel n in level mode and bit n = 0 puts it in edge mode. The enable words at 0x04 (rise/level enable) and 0x10 (fall enable/polarity) can be written and read back directly.
- R3: A write to 0x08 or 0x14 sets only those bits of the rise or fall enable that are 1 in the data. A write to 0x0C or 0x18 clears only those bits. Zero data bits leave the enables unchanged, and these four alias addresses read as 0.
- R4: Each input passes through two synchronizing flops. In edge mode with the rise enable set, a rising input sets status bit n at 0x24 and raises `irq_out[n]`. The output goes high on the third clock edge after the input changes, not earlier.
- R5: In edge mode, falling detection is controlled only by the fall enable and rising detection only by the rise enable. Both may be on at once.
- R6: An edge-mode status bit stays set after the input returns and after both enables are removed. `irq_out[n]` equals that status bit ANDed with (rise enable OR fall enable).
- R7: In edge mode, writing 1 to bit n at 0x24 clears status bit n. Zero bits have no effect.
- R8: In level mode, status bit n and `irq_out[n]` are 1 exactly when the rise enable is 1 and the synchronized input equals the fall-enable bit (1 = active high, 0 = active low). This appears two clock edges after the input changes.
- R9: In level mode, writing ones to 0x24 has no effect on status or `irq_out`.
- R10: The raw rising flags at 0x1C and falling flags at 0x20 record edges even on disabled channels. Writing 1 to bit n of either word clears that flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Asynchronous pin inputs, one per channel |
| irq_out | output | 8 | Interrupt line per channel |

## Verification
A wrong enable bit shows up on the next read of 0x04 or 0x10, and on `irq_out` as soon as an edge or level arrives. A lost or spuriously cleared edge status bit is visible immediately at 0x24 and on the same cycle at `irq_out`. Because synchronizer depth decides the exact edge on which `irq_out` moves, the bench samples one edge early and on the expected edge. That way an extra or missing stage is caught within three cycles of the input change.

// File: rtl/pinirq_pkg.sv
// Package: register addresses and the decoded write strobes shared by the
// pin interrupt controller. Assumes byte addresses on 32-bit word bounds.
package pinirq_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] A_RENA = 6'h04;
    localparam logic [ADDR_W-1:0] A_RSET = 6'h08;
    localparam logic [ADDR_W-1:0] A_RCLR = 6'h0C;
    localparam logic [ADDR_W-1:0] A_FENA = 6'h10;
    localparam logic [ADDR_W-1:0] A_FSET = 6'h14;
    localparam logic [ADDR_W-1:0] A_FCLR = 6'h18;
    localparam logic [ADDR_W-1:0] A_RFLG = 6'h1C;
    localparam logic [ADDR_W-1:0] A_FFLG = 6'h20;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h24;

    typedef struct packed {
        logic mode_we;
        logic rena_we;
        logic rena_set;
        logic rena_clr;
        logic fena_we;
        logic fena_set;
        logic fena_clr;
        logic rflg_clr;
        logic fflg_clr;
        logic stat_clr;
    } wr_dec_t;
endpackage

// File: rtl/pinirq_sync.sv
// Module: multi-stage synchronizer that also keeps one extra delayed copy,
// so that the caller can compare the current and previous synchronized
// value. Assumes asynchronous inputs; all stages reset to 0.
module pinirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] stg;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            // One register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= (g == 0) ? din : stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign cur  = stg[STAGES-1];
    assign prev = stg[STAGES];
endmodule

// File: rtl/pinirq_regs.sv
// Module: mode and enable registers with direct, set-alias and clear-alias
// writes. Assumes the decode struct carries at most one strobe per cycle.
module pinirq_regs #(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pinirq_pkg::wr_dec_t  dec,
    input  logic [NCH-1:0]       wbits,
    output logic [NCH-1:0]       mode,
    output logic [NCH-1:0]       rena,
    output logic [NCH-1:0]       fena
);
    // Mode word: one bit per channel, 1 = level.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode <= '0;
        else if (dec.mode_we) mode <= wbits;
    end

    // Rise / level enable with its set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)            rena <= '0;
        else if (dec.rena_we)  rena <= wbits;
        else if (dec.rena_set) rena <= rena | wbits;
        else if (dec.rena_clr) rena <= rena & ~wbits;
    end

    // Fall enable / level polarity with its set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)            fena <= '0;
        else if (dec.fena_we)  fena <= wbits;
        else if (dec.fena_set) fena <= fena | wbits;
        else if (dec.fena_clr) fena <= fena & ~wbits;
    end
endmodule

// File: rtl/pinirq_chan.sv
// Module: one channel's edge flags, sticky edge status and level evaluation.
// Assumes cur/prev come from a synchronizer; clear inputs are per channel.
module pinirq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic rena,
    input  logic fena,
    input  logic cur,
    input  logic prev,
    input  logic rflg_clr,
    input  logic fflg_clr,
    input  logic stat_clr,
    output logic rflg,
    output logic fflg,
    output logic edge_st,
    output logic stat,
    output logic irq
);
    logic rise_ev;
    logic fall_ev;
    logic lvl_hit;

    assign rise_ev = cur & ~prev;
    assign fall_ev = ~cur & prev;
    assign lvl_hit = rena & (cur == fena);

    // Raw rising flag: any rising edge sets it, write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        rflg <= 1'b0;
        else if (rise_ev)  rflg <= 1'b1;
        else if (rflg_clr) rflg <= 1'b0;
    end

    // Raw falling flag: any falling edge sets it, write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        fflg <= 1'b0;
        else if (fall_ev)  fflg <= 1'b1;
        else if (fflg_clr) fflg <= 1'b0;
    end

    // Sticky edge status: enabled edges set it, write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      edge_st <= 1'b0;
        else if (mode)                                   edge_st <= 1'b0;
        else if ((rise_ev & rena) | (fall_ev & fena))    edge_st <= 1'b1;
        else if (stat_clr)                               edge_st <= 1'b0;
    end

    assign stat = mode ? lvl_hit : edge_st;
    assign irq  = mode ? lvl_hit : (edge_st & (rena | fena));
endmodule

// File: rtl/pinirq_ctrl.sv
// Module: top of the eight-channel pin interrupt controller. Decodes the
// register bus, holds the enables, synchronizes the pins and runs one
// channel slice per input. Assumes single-cycle write strobes and a
// combinational read of the addressed word.
module pinirq_ctrl #(
    parameter int NCH         = 8,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [pinirq_pkg::ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]                 reg_wdata,
    output logic [DW-1:0]                 reg_rdata,
    input  logic [NCH-1:0]                pin_in,
    output logic [NCH-1:0]                irq_out
);
    import pinirq_pkg::*;

    localparam int PAD = DW - NCH;

    wr_dec_t        dec;
    logic [NCH-1:0] wbits;
    logic [NCH-1:0] mode, rena, fena;
    logic [NCH-1:0] cur, prev;
    logic [NCH-1:0] rflg, fflg, edge_st, stat;
    logic           unused_hi;

    assign wbits     = reg_wdata[NCH-1:0];
    assign unused_hi = ^reg_wdata[DW-1:NCH];

    // Write decode: one strobe per register address.
    always_comb begin
        dec          = '0;
        dec.mode_we  = reg_wr && (reg_addr == A_MODE);
        dec.rena_we  = reg_wr && (reg_addr == A_RENA);
        dec.rena_set = reg_wr && (reg_addr == A_RSET);
        dec.rena_clr = reg_wr && (reg_addr == A_RCLR);
        dec.fena_we  = reg_wr && (reg_addr == A_FENA);
        dec.fena_set = reg_wr && (reg_addr == A_FSET);
        dec.fena_clr = reg_wr && (reg_addr == A_FCLR);
        dec.rflg_clr = reg_wr && (reg_addr == A_RFLG);
        dec.fflg_clr = reg_wr && (reg_addr == A_FFLG);
        dec.stat_clr = reg_wr && (reg_addr == A_STAT);
    end

    pinirq_regs #(.NCH(NCH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (dec),
        .wbits (wbits),
        .mode  (mode),
        .rena  (rena),
        .fena  (fena)
    );

    pinirq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .cur   (cur),
        .prev  (prev)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chan
            pinirq_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (mode[c]),
                .rena     (rena[c]),
                .fena     (fena[c]),
                .cur      (cur[c]),
                .prev     (prev[c]),
                .rflg_clr (dec.rflg_clr & wbits[c]),
                .fflg_clr (dec.fflg_clr & wbits[c]),
                .stat_clr (dec.stat_clr & wbits[c]),
                .rflg     (rflg[c]),
                .fflg     (fflg[c]),
                .edge_st  (edge_st[c]),
                .stat     (stat[c]),
                .irq      (irq_out[c])
            );
        end
    endgenerate

    // Read mux: alias and unused addresses read as zero.
    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = {{PAD{1'b0}}, mode};
            A_RENA:  reg_rdata = {{PAD{1'b0}}, rena};
            A_FENA:  reg_rdata = {{PAD{1'b0}}, fena};
            A_RFLG:  reg_rdata = {{PAD{1'b0}}, rflg};
            A_FFLG:  reg_rdata = {{PAD{1'b0}}, fflg};
            A_STAT:  reg_rdata = {{PAD{1'b0}}, stat};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinirq_chk.sv
// Module: property checker for pinirq_ctrl, attached with bind below.
// Assumes it sees the top's bus inputs and its internal enable and status.
module pinirq_chk #(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [pinirq_pkg::ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]                 reg_wdata,
    input logic [NCH-1:0]                mode,
    input logic [NCH-1:0]                rena,
    input logic [NCH-1:0]                fena,
    input logic [NCH-1:0]                edge_st,
    input logic [NCH-1:0]                irq_out
);
    import pinirq_pkg::*;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0)); // R1

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RSET) |=> (rena == ($past(rena) | $past(reg_wdata[NCH-1:0])))); // R3

    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FCLR) |=> (fena == ($past(fena) & ~$past(reg_wdata[NCH-1:0])))); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> ((edge_st & $past(edge_st) & ~$past(mode)) == ($past(edge_st) & ~$past(mode)))); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~(rena | fena)) == '0)); // R6

    AST_LEVEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & mode & ~rena) == '0)); // R8
endmodule

bind pinirq_ctrl pinirq_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode      (mode),
    .rena      (rena),
    .fena      (fena),
    .edge_st   (edge_st),
    .irq_out   (irq_out)
);

// File: tb/test_pinirq_ctrl.sv
// Bench: register-semantics vector table, then directed edge and level tests.
module test_pinirq_ctrl;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [5:0]  wa;
        logic [31:0] wd;
        logic [5:0]  ra;
        logic [31:0] ex;
    } vec_t;

    // Write, then read back: R2 direct writes, R3 aliases.
    localparam vec_t VEC [12] = '{
        '{6'h04, 32'h05, 6'h04, 32'h05},
        '{6'h08, 32'h02, 6'h04, 32'h07},
        '{6'h08, 32'h00, 6'h04, 32'h07},
        '{6'h0C, 32'h04, 6'h04, 32'h03},
        '{6'h0C, 32'h00, 6'h04, 32'h03},
        '{6'h08, 32'h10, 6'h08, 32'h00},
        '{6'h0C, 32'h00, 6'h04, 32'h13},
        '{6'h10, 32'hF0, 6'h10, 32'hF0},
        '{6'h14, 32'h01, 6'h10, 32'hF1},
        '{6'h18, 32'h80, 6'h10, 32'h71},
        '{6'h00, 32'h0F, 6'h00, 32'h0F},
        '{6'h00, 32'h00, 6'h00, 32'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  irq_out;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinirq_ctrl i_pinirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        step(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        foreach (VEC[i]) begin
            rd(VEC[i].ra, v);
            chk("R1 reset read", v, 32'h0);
        end
        rd(6'h1C, v); chk("R1 reset rise flags", v, 0);
        rd(6'h24, v); chk("R1 reset status", v, 0);
        chk("R1 reset irq", {24'h0, irq_out}, 0);

        // R2 R3: table walk
        foreach (VEC[i]) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, v);
            chk($sformatf("R2/R3 vector %0d", i), v, VEC[i].ex);
        end
        wr(6'h04, 0);
        wr(6'h10, 0);

        // R4: rising edge on channel 0, latency of three edges
        wr(6'h08, 32'h01);
        pin_in[0] = 1'b1;
        step(2);
        chk("R4 irq not before third edge", {31'h0, irq_out[0]}, 0);
        step(1);
        chk("R4 irq on rise", {31'h0, irq_out[0]}, 1);
        rd(6'h24, v); chk("R4 status bit0", v, 32'h01);
        rd(6'h1C, v); chk("R10 rise flag bit0", v, 32'h01);

        // R6: sticky after input drop and after disable
        pin_in[0] = 1'b0;
        step(3);
        chk("R6 irq sticky", {31'h0, irq_out[0]}, 1);
        rd(6'h20, v); chk("R10 fall flag on disabled fall", v, 32'h01);
        wr(6'h0C, 32'h01);
        chk("R6 irq gated by enable", {31'h0, irq_out[0]}, 0);
        rd(6'h24, v); chk("R6 status kept when disabled", v, 32'h01);
        wr(6'h08, 32'h01);
        chk("R6 irq back on re-enable", {31'h0, irq_out[0]}, 1);

        // R7: write-one clear of status
        wr(6'h24, 32'h00);
        rd(6'h24, v); chk("R7 zero write keeps status", v, 32'h01);
        wr(6'h24, 32'h01);
        rd(6'h24, v); chk("R7 status cleared", v, 0);
        chk("R7 irq cleared", {31'h0, irq_out[0]}, 0);
        wr(6'h1C, 32'h01);
        rd(6'h1C, v); chk("R10 rise flag cleared", v, 0);
        wr(6'h20, 32'h01);
        rd(6'h20, v); chk("R10 fall flag cleared", v, 0);
        wr(6'h0C, 32'h01);

        // R5: channel 1 falling only
        wr(6'h14, 32'h02);
        pin_in[1] = 1'b1;
        step(4);
        chk("R5 rise ignored with fall enable only", {31'h0, irq_out[1]}, 0);
        rd(6'h1C, v); chk("R10 rise flag on fall-only channel", v, 32'h02);
        pin_in[1] = 1'b0;
        step(3);
        chk("R5 irq on fall", {31'h0, irq_out[1]}, 1);
        wr(6'h24, 32'h02);
        wr(6'h1C, 32'h02);
        wr(6'h20, 32'h02);
        wr(6'h18, 32'h02);

        // R5: channel 2 both edges
        wr(6'h08, 32'h04);
        wr(6'h14, 32'h04);
        pin_in[2] = 1'b1;
        step(3);
        chk("R5 both: rise", {31'h0, irq_out[2]}, 1);
        wr(6'h24, 32'h04);
        chk("R5 both: cleared", {31'h0, irq_out[2]}, 0);
        pin_in[2] = 1'b0;
        step(3);
        chk("R5 both: fall", {31'h0, irq_out[2]}, 1);
        wr(6'h24, 32'h04);
        wr(6'h0C, 32'h04);
        wr(6'h18, 32'h04);

        // R8: channel 3 level, active high
        wr(6'h00, 32'h08);
        wr(6'h08, 32'h08);
        wr(6'h14, 32'h08);
        chk("R8 inactive level low", {31'h0, irq_out[3]}, 0);
        pin_in[3] = 1'b1;
        step(1);
        chk("R8 not after one edge", {31'h0, irq_out[3]}, 0);
        step(1);
        chk("R8 active high", {31'h0, irq_out[3]}, 1);
        rd(6'h24, v); chk("R8 status follows level", v, 32'h08);
        wr(6'h24, 32'h08);
        chk("R9 status write ignored in level mode", {31'h0, irq_out[3]}, 1);
        rd(6'h24, v); chk("R9 status unchanged", v, 32'h08);
        pin_in[3] = 1'b0;
        step(2);
        chk("R8 level released", {31'h0, irq_out[3]}, 0);

        // R8: channel 4 level, active low
        wr(6'h00, 32'h18);
        wr(6'h08, 32'h10);
        chk("R8 active low asserted", {31'h0, irq_out[4]}, 1);
        pin_in[4] = 1'b1;
        step(2);
        chk("R8 active low released", {31'h0, irq_out[4]}, 0);
        wr(6'h0C, 32'h10);
        pin_in[4] = 1'b0;
        step(2);
        chk("R8 level needs enable", {31'h0, irq_out[4]}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule